// File: doc/BRIEF.md
# Vector-to-Multimedia Register Move Unit

This unit decodes and executes a single instruction. The instruction copies the low 64 bits of a 128-bit vector register into one of eight 64-bit multimedia registers. Those multimedia registers share storage with the x87 register stack. The four instruction bytes arrive in parallel with a start strobe. The prefix flags, the control words, the feature word and the pending floating-point flag arrive alongside them.

The unit drives the index of the source vector register and reads that register's contents in the same cycle. One clock after the strobe, it raises a one-cycle done pulse together with an encoded fault code.

When no fault is raised, the unit:
- writes the destination multimedia register;
- issues a write of the x87 stack state that sets the top-of-stack pointer to zero and marks every tag as valid.

When a fault is raised, no write leaves the unit. Only the highest-priority fault is reported.

Top module: `mvq_move_unit`

## Requirements
- R1: The instruction is accepted only when op_bytes[7:0]=F2h, op_bytes[15:8]=0Fh and op_bytes[23:16]=D6h. Any other byte value gives fault code 1 (bad opcode). op_bytes[31:24] is the operand byte, laid out as mode [31:30], destination [29:27] and source [26:24].
- R2: On success, mm_wr_en pulses with mm_wr_idx equal to the destination field. mm_wr_data equals bits [63:0] of the vector data sampled at the strobe, and bits [127:64] have no effect on it.
- R3: vec_rd_idx is {pfx_ext_r & long_mode, source field}. The extension bit reaches registers 8 to 15 only in long mode; outside long mode it is ignored.
- R4: A mode field other than 2'b11 (a memory operand) gives fault code 1.
- R5: Fault code 1 is also raised when any of these holds: ctl0[2] is set; ctl4[9] is clear; feat_word[26] is clear; pfx_lock is set.
- R6: ctl0[3] set gives fault code 2 (unit not available).
- R7: fp_pending set gives fault code 3 (floating-point error).
- R8: Priority is code 1 over code 2 over code 3. Only the highest-priority fault is reported.
- R9: For any nonzero fault code, mm_wr_en and fpu_wr_en stay low.
- R10: On success, fpu_wr_en pulses with fpu_top=0 and fpu_tag=0 (all entries valid, 2 bits per entry).
- R11: done and fault_code appear in the cycle after start is sampled high, and last one cycle. Code 0 means no fault. After reset, done, both write enables and fault_code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Execute strobe |
| op_bytes | input | 32 | Three opcode bytes and the operand byte |
| pfx_lock | input | 1 | Bus-lock prefix present |
| pfx_ext_r | input | 1 | Register-extension prefix bit |
| long_mode | input | 1 | 64-bit operating mode |
| ctl0 | input | 32 | Control word 0 |
| ctl4 | input | 32 | Control word 4 |
| feat_word | input | 32 | Feature flag word |
| fp_pending | input | 1 | x87 exception pending |
| vec_rd_idx | output | 4 | Source vector register index |
| vec_rd_data | input | 128 | Source vector register contents |
| mm_wr_en | output | 1 | Multimedia register write strobe |
| mm_wr_idx | output | 3 | Multimedia register index |
| mm_wr_data | output | 64 | Multimedia register write data |
| fpu_wr_en | output | 1 | x87 stack state write strobe |
| fpu_top | output | 3 | New top-of-stack pointer |
| fpu_tag | output | 16 | New tag word |
| done | output | 1 | Completion pulse |
| fault_code | output | 2 | 0 none, 1 bad opcode, 2 unit not available, 3 floating-point error |

## Verification
The assertions assume that start is low throughout reset. They also assume that vec_rd_data is a combinational function of vec_rd_idx that settles within the strobe cycle. The bench meets both assumptions: it models the register file as an array indexed by the unit's own index output, and it drives stimulus only on falling edges with the strobe low during reset. Random fault conditions are each set with low probability, so most transactions succeed. Directed cases cover every single cause and every priority pairing.

// File: rtl/mvq_pkg.sv
package mvq_pkg;
   localparam int VEC_W  = 128;
   localparam int MM_W   = 64;
   localparam int CTL_W  = 32;
   localparam logic [7:0] OPB0 = 8'hF2;
   localparam logic [7:0] OPB1 = 8'h0F;
   localparam logic [7:0] OPB2 = 8'hD6;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_BADOP  = 2'd1,
      FLT_NOUNIT = 2'd2,
      FLT_FPERR  = 2'd3
   } flt_e;
endpackage

// File: rtl/mvq_decode.sv
module mvq_decode #(
   parameter int HAS_EXT = 1,
   parameter int VIDX_W  = 4,
   parameter int MIDX_W  = 3
) (
   input  logic [31:0]       op_bytes,
   input  logic              long_mode,
   input  logic              pfx_ext_r,
   output logic              op_match,
   output logic              reg_form,
   output logic [MIDX_W-1:0] dst_idx,
   output logic [VIDX_W-1:0] src_idx
);
   import mvq_pkg::*;

   logic [7:0] opnd;
   assign opnd     = op_bytes[31:24];
   assign op_match = (op_bytes[7:0] == OPB0) && (op_bytes[15:8] == OPB1) &&
                     (op_bytes[23:16] == OPB2);
   assign reg_form = (opnd[7:6] == 2'b11);
   assign dst_idx  = opnd[5:3];

   generate
      if (HAS_EXT != 0) begin : g_ext
         assign src_idx = {pfx_ext_r & long_mode, opnd[2:0]};
      end else begin : g_noext
         logic unused_ext;
         assign unused_ext = pfx_ext_r ^ long_mode;
         assign src_idx    = {1'b0, opnd[2:0]};
      end
   endgenerate
endmodule

// File: rtl/mvq_fault_chk.sv
module mvq_fault_chk #(
   parameter int CTL_W    = 32,
   parameter int TS_BIT   = 3,
   parameter int EM_BIT   = 2,
   parameter int OSS_BIT  = 9,
   parameter int FEAT_BIT = 26
) (
   input  logic             op_match,
   input  logic             reg_form,
   input  logic             pfx_lock,
   input  logic [CTL_W-1:0] ctl0,
   input  logic [CTL_W-1:0] ctl4,
   input  logic [CTL_W-1:0] feat_word,
   input  logic             fp_pending,
   output mvq_pkg::flt_e    code
);
   import mvq_pkg::*;

   if (TS_BIT >= CTL_W || EM_BIT >= CTL_W || OSS_BIT >= CTL_W || FEAT_BIT >= CTL_W) begin : g_bad_bit
      $error("mvq_fault_chk: control bit position out of range");
   end

   logic bad_op, no_unit;
   assign bad_op  = !op_match || !reg_form || pfx_lock || ctl0[EM_BIT] ||
                    !ctl4[OSS_BIT] || !feat_word[FEAT_BIT];
   assign no_unit = ctl0[TS_BIT];

   always_comb begin
      if (bad_op)          code = FLT_BADOP;
      else if (no_unit)    code = FLT_NOUNIT;
      else if (fp_pending) code = FLT_FPERR;
      else                 code = FLT_NONE;
   end
endmodule

// File: rtl/mvq_exec.sv
module mvq_exec #(
   parameter int MM_W   = 64,
   parameter int MIDX_W = 3,
   parameter int TOP_W  = 3,
   parameter int TAG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  mvq_pkg::flt_e     code,
   input  logic [MIDX_W-1:0] dst_idx,
   input  logic [MM_W-1:0]   src_lo,
   output logic              mm_wr_en,
   output logic [MIDX_W-1:0] mm_wr_idx,
   output logic [MM_W-1:0]   mm_wr_data,
   output logic              fpu_wr_en,
   output logic [TOP_W-1:0]  fpu_top,
   output logic [TAG_W-1:0]  fpu_tag,
   output logic              done,
   output logic [1:0]        fault_code
);
   import mvq_pkg::*;

   logic ok;
   assign ok = (code == FLT_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mm_wr_en   <= 1'b0;
         mm_wr_idx  <= '0;
         mm_wr_data <= '0;
         fpu_wr_en  <= 1'b0;
         fpu_top    <= '0;
         fpu_tag    <= '0;
         done       <= 1'b0;
         fault_code <= 2'd0;
      end else begin
         done      <= start;
         mm_wr_en  <= start && ok;
         fpu_wr_en <= start && ok;
         if (start) begin
            fault_code <= code;
            if (ok) begin
               mm_wr_idx  <= dst_idx;
               mm_wr_data <= src_lo;
               fpu_top    <= '0;
               fpu_tag    <= '0;
            end
         end else begin
            fault_code <= 2'd0;
         end
      end
   end

   AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start) |-> done) else $error("done missing");           // R11
   AST_DONE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(start) |-> (!done && !mm_wr_en)) else $error("stray done"); // R11
   AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault_code != 2'd0) |-> (!mm_wr_en && !fpu_wr_en)) else $error("write on fault"); // R9
   AST_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
      mm_wr_en |-> (mm_wr_data == $past(src_lo) && mm_wr_idx == $past(dst_idx))) else $error("data"); // R2
   AST_STATE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      fpu_wr_en |-> (mm_wr_en && fpu_top == '0 && fpu_tag == '0)) else $error("fpu state"); // R10
endmodule

// File: rtl/mvq_move_unit.sv
module mvq_move_unit #(
   parameter int VEC_W    = mvq_pkg::VEC_W,
   parameter int MM_W     = mvq_pkg::MM_W,
   parameter int NUM_VEC  = 16,
   parameter int NUM_MM   = 8,
   parameter int CTL_W    = mvq_pkg::CTL_W,
   parameter int HAS_EXT  = 1,
   parameter int TS_BIT   = 3,
   parameter int EM_BIT   = 2,
   parameter int OSS_BIT  = 9,
   parameter int FEAT_BIT = 26,
   localparam int VIDX_W  = $clog2(NUM_VEC),
   localparam int MIDX_W  = $clog2(NUM_MM),
   localparam int TAG_W   = 2 * NUM_MM
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [31:0]       op_bytes,
   input  logic              pfx_lock,
   input  logic              pfx_ext_r,
   input  logic              long_mode,
   input  logic [CTL_W-1:0]  ctl0,
   input  logic [CTL_W-1:0]  ctl4,
   input  logic [CTL_W-1:0]  feat_word,
   input  logic              fp_pending,
   output logic [VIDX_W-1:0] vec_rd_idx,
   input  logic [VEC_W-1:0]  vec_rd_data,
   output logic              mm_wr_en,
   output logic [MIDX_W-1:0] mm_wr_idx,
   output logic [MM_W-1:0]   mm_wr_data,
   output logic              fpu_wr_en,
   output logic [MIDX_W-1:0] fpu_top,
   output logic [TAG_W-1:0]  fpu_tag,
   output logic              done,
   output logic [1:0]        fault_code
);
   import mvq_pkg::*;

   if (VEC_W < 2 * MM_W) begin : g_bad_w
      $error("mvq_move_unit: vector width must hold two multimedia words");
   end
   if (NUM_VEC != 16 || NUM_MM != 8) begin : g_bad_n
      $error("mvq_move_unit: operand byte fields need 16 vector and 8 multimedia registers");
   end

   logic              op_match, reg_form;
   logic [MIDX_W-1:0] dst_idx;
   flt_e              code;
   logic              unused_hi;

   assign unused_hi = ^vec_rd_data[VEC_W-1:MM_W];

   mvq_decode #(.HAS_EXT(HAS_EXT), .VIDX_W(VIDX_W), .MIDX_W(MIDX_W)) u_dec (
      .op_bytes (op_bytes),
      .long_mode(long_mode),
      .pfx_ext_r(pfx_ext_r),
      .op_match (op_match),
      .reg_form (reg_form),
      .dst_idx  (dst_idx),
      .src_idx  (vec_rd_idx)
   );

   mvq_fault_chk #(.CTL_W(CTL_W), .TS_BIT(TS_BIT), .EM_BIT(EM_BIT),
                   .OSS_BIT(OSS_BIT), .FEAT_BIT(FEAT_BIT)) u_chk (
      .op_match  (op_match),
      .reg_form  (reg_form),
      .pfx_lock  (pfx_lock),
      .ctl0      (ctl0),
      .ctl4      (ctl4),
      .feat_word (feat_word),
      .fp_pending(fp_pending),
      .code      (code)
   );

   mvq_exec #(.MM_W(MM_W), .MIDX_W(MIDX_W), .TOP_W(MIDX_W), .TAG_W(TAG_W)) u_exe (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .code      (code),
      .dst_idx   (dst_idx),
      .src_lo    (vec_rd_data[MM_W-1:0]),
      .mm_wr_en  (mm_wr_en),
      .mm_wr_idx (mm_wr_idx),
      .mm_wr_data(mm_wr_data),
      .fpu_wr_en (fpu_wr_en),
      .fpu_top   (fpu_top),
      .fpu_tag   (fpu_tag),
      .done      (done),
      .fault_code(fault_code)
   );

   AST_LOCK_BADOP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start && pfx_lock) |-> fault_code == 2'd1) else $error("lock"); // R5
   AST_MEM_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start && op_bytes[31:30] != 2'b11) |-> fault_code == 2'd1) else $error("mode"); // R4
   AST_FP_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start && fp_pending) |-> (done && fault_code != 2'd0)) else $error("fp pending"); // R7
   AST_NOUNIT_OVER_FP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start && ctl0[TS_BIT]) |-> fault_code inside {2'd1, 2'd2}) else $error("prio"); // R8
endmodule

// File: tb/tb_mvq_move_unit.sv
module tb_mvq_move_unit;
   localparam int CLK_P = 10;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [31:0] op_bytes = '0, ctl0 = '0, ctl4 = '0, feat_word = '0;
   logic pfx_lock = 0, pfx_ext_r = 0, long_mode = 0, fp_pending = 0;
   logic [3:0]   vec_rd_idx;
   logic [127:0] vec_rd_data;
   logic mm_wr_en, fpu_wr_en, done;
   logic [2:0] mm_wr_idx, fpu_top;
   logic [63:0] mm_wr_data;
   logic [15:0] fpu_tag;
   logic [1:0] fault_code;
   logic [127:0] vregs [16];
   int checks = 0, failures = 0;

   assign vec_rd_data = vregs[vec_rd_idx];
   always #(CLK_P/2) clk = ~clk;

   mvq_move_unit dut (.*);

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_fault(input logic [31:0] ob, input logic lk,
         input logic [31:0] c0, input logic [31:0] c4, input logic [31:0] ft, input logic fp);
      if (ob[23:0] != 24'hD60FF2 || ob[31:30] != 2'b11 || lk || c0[2] || !c4[9] || !ft[26])
         return 2'd1;
      if (c0[3]) return 2'd2;
      if (fp)    return 2'd3;
      return 2'd0;
   endfunction

   task automatic run(input logic [31:0] ob, input logic lk, input logic ex, input logic lm,
         input logic [31:0] c0, input logic [31:0] c4, input logic [31:0] ft, input logic fp);
      logic [3:0] sidx;
      logic [1:0] ef;
      @(negedge clk);
      op_bytes = ob; pfx_lock = lk; pfx_ext_r = ex; long_mode = lm;
      ctl0 = c0; ctl4 = c4; feat_word = ft; fp_pending = fp; start = 1'b1;
      sidx = {ex & lm, ob[26:24]};
      ef = exp_fault(ob, lk, c0, c4, ft, fp);
      #1;
      chk(vec_rd_idx == sidx, "R3 source index", vec_rd_idx, sidx);
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1, "R11 done pulse", done, 1);
      chk(fault_code == ef, "R8 fault code (R1 R4 R5 R6 R7)", fault_code, ef);
      if (ef != 2'd0) begin
         chk(!mm_wr_en && !fpu_wr_en, "R9 no write on fault", {mm_wr_en, fpu_wr_en}, 0);
      end else begin
         chk(mm_wr_en && mm_wr_idx == ob[29:27], "R2 write index", {mm_wr_en, mm_wr_idx}, {1'b1, ob[29:27]});
         chk(mm_wr_data == vregs[sidx][63:0], "R2 write data", mm_wr_data, vregs[sidx][63:0]);
         chk(fpu_wr_en && fpu_top == 3'd0 && fpu_tag == 16'd0, "R10 stack state",
             {fpu_wr_en, fpu_top, fpu_tag}, {1'b1, 19'd0});
      end
      @(negedge clk);
      chk(!done && !mm_wr_en && !fpu_wr_en, "R11 single cycle", {done, mm_wr_en, fpu_wr_en}, 0);
   endtask

   localparam logic [31:0] C4OK = 32'h200, FTOK = 32'h0400_0000;

   function automatic logic [31:0] mk(input logic [1:0] md, input logic [2:0] rg, input logic [2:0] rm);
      return {md, rg, rm, 24'hD60FF2};
   endfunction

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5EED);
      for (int i = 0; i < 16; i++) vregs[i] = {$urandom, $urandom, $urandom, $urandom};
      repeat (3) @(negedge clk);
      chk(!done && !mm_wr_en && !fpu_wr_en && fault_code == 0, "R11 reset state",
          {done, mm_wr_en, fpu_wr_en, fault_code}, 0);
      rst_n = 1'b1;
      // directed
      run(mk(2'b11, 3'd5, 3'd2), 0, 0, 1, 0, C4OK, FTOK, 0);          // R2 basic
      run(mk(2'b11, 3'd1, 3'd7), 0, 1, 1, 0, C4OK, FTOK, 0);          // R3 extended reg 15
      run(mk(2'b11, 3'd1, 3'd7), 0, 1, 0, 0, C4OK, FTOK, 0);          // R3 ext ignored
      run(mk(2'b11, 3'd0, 3'd0) ^ 32'h10, 0, 0, 1, 0, C4OK, FTOK, 0); // R1 bad opcode
      run(mk(2'b01, 3'd3, 3'd3), 0, 0, 1, 0, C4OK, FTOK, 0);          // R4 memory form
      run(mk(2'b11, 3'd3, 3'd3), 1, 0, 1, 0, C4OK, FTOK, 0);          // R5 lock
      run(mk(2'b11, 3'd3, 3'd3), 0, 0, 1, 32'h4, C4OK, FTOK, 0);      // R5 emulation bit
      run(mk(2'b11, 3'd3, 3'd3), 0, 0, 1, 0, 0, FTOK, 0);             // R5 ctl4 clear
      run(mk(2'b11, 3'd3, 3'd3), 0, 0, 1, 0, C4OK, 0, 0);             // R5 feature clear
      run(mk(2'b11, 3'd4, 3'd6), 0, 0, 1, 32'h8, C4OK, FTOK, 0);      // R6
      run(mk(2'b11, 3'd4, 3'd6), 0, 0, 1, 0, C4OK, FTOK, 1);          // R7
      run(mk(2'b11, 3'd4, 3'd6), 0, 0, 1, 32'h8, C4OK, FTOK, 1);      // R8 unit over fp
      run(mk(2'b11, 3'd4, 3'd6), 1, 0, 1, 32'h8, C4OK, FTOK, 1);      // R8 badop over all
      // random
      for (int i = 0; i < 300; i++) begin
         logic [31:0] ob, c0, c4, ft;
         ob = mk(($urandom % 8 == 0) ? 2'($urandom) : 2'b11, 3'($urandom), 3'($urandom));
         if ($urandom % 16 == 0) ob[15:8] = 8'($urandom);
         c0 = $urandom & 32'hFFFF_FFF3;
         if ($urandom % 6 == 0) c0[2] = 1'b1;
         if ($urandom % 6 == 0) c0[3] = 1'b1;
         c4 = $urandom | C4OK; if ($urandom % 8 == 0) c4[9] = 1'b0;
         ft = $urandom | FTOK; if ($urandom % 8 == 0) ft[26] = 1'b0;
         vregs[$urandom % 16] = {$urandom, $urandom, $urandom, $urandom};
         run(ob, ($urandom % 10 == 0), 1'($urandom), 1'($urandom), c0, c4, ft, ($urandom % 6 == 0));
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule